// File: doc/BRIEF.md
# Timer Interrupt Pending-and-Acknowledge Throttle

This block sits between an interval timer and an interrupt controller. Rather than passing every timer expiry straight through as an interrupt, it keeps a saturating count of the expiries that have not yet been serviced. It emits a single-cycle interrupt pulse only when three things hold: the requester asks for an injection, the count is nonzero, and the previously issued interrupt has been acknowledged. Timer ticks that arrive while the processor is busy are therefore folded into the count and are replayed one at a time. Each replay waits for the acknowledge of the one before it.

Each acknowledge retires one pending tick and re-arms delivery. Unmasking the interrupt line, reloading the timer, or reset throws away the backlog and re-arms delivery. On a reload the block also captures the channel's counting mode and reports whether the timer now runs periodically, as a one-shot, or not at all.

Top module: `tick_throttle`

## Requirements
- R1: While reset is asserted and right after it: pending count 0, `pending_o` 0, `irq_o` 0, both timer-run flags 0, and delivery armed (the acknowledged flag is set).
- R2: Each cycle with `expire_i` high, and no acknowledge, unmask or reload, raises `pend_count_o` by one. `pending_o` is 1 exactly when the count is nonzero.
- R3: `irq_o` is high for one cycle, the cycle after a cycle in which `inject_req_i` was high, the count was nonzero, the acknowledged flag was set and no unmask or reload was present. Issuing clears the acknowledged flag, so further requests give no pulse until an acknowledge or a clear arrives. A request while the count is 0 gives no pulse.
- R4: `ack_i` lowers the count by one, never below 0, and sets the acknowledged flag.
- R5: `unmask_i` sets the count to 0 and sets the acknowledged flag. It overrides any expiry, acknowledge or injection request in the same cycle.
- R6: `reload_i` clears the count and sets the acknowledged flag, with the same priority as R5.
- R7: The count saturates at 2^CNT_W-1. Further expiries leave it there.
- R8: An expiry and an acknowledge in the same cycle leave the count unchanged and set the acknowledged flag.
- R9: On `reload_i` the 3-bit `mode_i` is captured. Values 2 and 3 give `run_periodic_o`=1. Values 1 and 4 give `run_oneshot_o`=1. Values 0, 5, 6 and 7 give both 0. The flags hold until the next reload.
- R10: Issuing an interrupt does not change the count. Only an acknowledge retires a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| expire_i | input | 1 | Timer expiry pulse |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| inject_req_i | input | 1 | Request to deliver a pending interrupt |
| unmask_i | input | 1 | Interrupt line unmasked event |
| reload_i | input | 1 | Timer reload event; captures `mode_i` |
| mode_i | input | 3 | Channel counting mode sampled on reload |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pending_o | output | 1 | Pending count is nonzero |
| pend_count_o | output | CNT_W | Current pending count |
| run_periodic_o | output | 1 | Timer runs periodically |
| run_oneshot_o | output | 1 | Timer runs once |

## Verification
The acknowledged flag cannot be seen at the ports. The bench therefore infers it by sending an injection request and checking whether a pulse follows. Every scenario is ordered so that the flag is known to be cleared by an earlier issue before the event under test is applied. This lets same-cycle expiry plus acknowledge, and unmask or reload, each prove that they re-armed delivery. Saturation takes more than 2^CNT_W expiries in a row with no acknowledge, followed by one acknowledge to show that the count sits exactly at the ceiling.

// File: rtl/tick_throttle_pkg.sv
package tick_throttle_pkg;

  typedef enum logic [1:0] {
    RUN_STOP     = 2'd0,
    RUN_ONESHOT  = 2'd1,
    RUN_PERIODIC = 2'd2
  } run_kind_e;

  function automatic run_kind_e classify_mode(input logic [2:0] m);
    run_kind_e k;
    case (m)
      3'd2, 3'd3: k = RUN_PERIODIC;
      3'd1, 3'd4: k = RUN_ONESHOT;
      default:    k = RUN_STOP;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/tick_pend_counter.sv
module tick_pend_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = CNT_ZERO;
      cnt_en = 1'b1;
    end else if (inc && !dec) begin
      if (cnt_q != CNT_MAX) begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end else if (dec && !inc) begin
      if (cnt_q != CNT_ZERO) begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc && !dec && !clr) |=> (cnt_q == CNT_MAX)); // R7
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_ZERO && dec && !inc && !clr) |=> (cnt_q == CNT_ZERO)); // R4
  AST_CNT_NET: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !clr) |=> $stable(cnt_q)); // R8
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == CNT_ZERO)); // R5
endmodule

// File: rtl/tick_irq_gate.sv
module tick_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic inject,
  input  logic ack,
  input  logic clr,
  input  logic pend_nz,
  output logic irq
);
  logic acked_q, acked_d, acked_en;
  logic irq_q, irq_d;
  logic issue;

  assign issue = inject && pend_nz && acked_q && !clr;

  always_comb begin
    acked_d  = acked_q;
    acked_en = 1'b0;
    if (clr || ack) begin
      acked_d  = 1'b1;
      acked_en = 1'b1;
    end else if (issue) begin
      acked_d  = 1'b0;
      acked_en = 1'b1;
    end
    irq_d = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acked_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      if (acked_en) acked_q <= acked_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !$past(ack)) |-> !acked_q); // R3
  AST_FLAG_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || clr) |=> acked_q); // R4
endmodule

// File: rtl/tick_mode_track.sv
module tick_mode_track
  import tick_throttle_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reload,
  input  logic [2:0] mode,
  output logic       periodic,
  output logic       oneshot
);
  run_kind_e kind_q, kind_d;

  assign kind_d = classify_mode(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      kind_q <= RUN_STOP;
    else if (reload) kind_q <= kind_d;
  end

  assign periodic = (kind_q == RUN_PERIODIC);
  assign oneshot  = (kind_q == RUN_ONESHOT);

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(kind_q)); // R9
endmodule

// File: rtl/tick_throttle.sv
module tick_throttle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire_i,
  input  logic             ack_i,
  input  logic             inject_req_i,
  input  logic             unmask_i,
  input  logic             reload_i,
  input  logic [2:0]       mode_i,
  output logic             irq_o,
  output logic             pending_o,
  output logic [CNT_W-1:0] pend_count_o,
  output logic             run_periodic_o,
  output logic             run_oneshot_o
);
  logic             clr_evt;
  logic [CNT_W-1:0] cnt;

  assign clr_evt = unmask_i || reload_i;

  tick_pend_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (expire_i),
    .dec   (ack_i),
    .clr   (clr_evt),
    .cnt   (cnt)
  );

  tick_irq_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .inject  (inject_req_i),
    .ack     (ack_i),
    .clr     (clr_evt),
    .pend_nz (pending_o),
    .irq     (irq_o)
  );

  tick_mode_track u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (reload_i),
    .mode     (mode_i),
    .periodic (run_periodic_o),
    .oneshot  (run_oneshot_o)
  );

  assign pend_count_o = cnt;
  assign pending_o    = (cnt != '0);

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(pending_o && inject_req_i)); // R3
  AST_ISSUE_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !$past(expire_i || ack_i || clr_evt)) |-> $stable(pend_count_o)); // R10
  AST_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_periodic_o, run_oneshot_o})); // R9
endmodule

// File: tb/tb_tick_throttle.sv
`timescale 1ns/1ps
module tb_tick_throttle;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic expire_i, ack_i, inject_req_i, unmask_i, reload_i;
  logic [2:0] mode_i;
  logic irq_o, pending_o, run_periodic_o, run_oneshot_o;
  logic [CNT_W-1:0] pend_count_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  tick_throttle #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .expire_i(expire_i), .ack_i(ack_i),
    .inject_req_i(inject_req_i), .unmask_i(unmask_i), .reload_i(reload_i),
    .mode_i(mode_i), .irq_o(irq_o), .pending_o(pending_o),
    .pend_count_o(pend_count_o), .run_periodic_o(run_periodic_o),
    .run_oneshot_o(run_oneshot_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs, return at the following negedge
  task automatic cyc(input bit e, input bit a, input bit i, input bit u,
                     input bit r, input logic [2:0] m);
    expire_i = e; ack_i = a; inject_req_i = i; unmask_i = u; reload_i = r; mode_i = m;
    @(negedge clk);
    expire_i = 0; ack_i = 0; inject_req_i = 0; unmask_i = 0; reload_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", pend_count_o, 0);
    chk("R1 pending", pending_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 periodic", run_periodic_o, 0);
    chk("R1 oneshot", run_oneshot_o, 0);
    cyc(1,0,0,0,0,0);
    cyc(0,0,1,0,0,0);
    chk("R1 armed after reset", irq_o, 1);
    cyc(0,1,0,0,0,0);
    chk("R1 back to zero", pend_count_o, 0);
  endtask

  task automatic t_count();
    for (int k = 0; k < 3; k++) cyc(1,0,0,0,0,0);
    chk("R2 count three", pend_count_o, 3);
    chk("R2 pending flag", pending_o, 1);
  endtask

  task automatic t_issue();
    cyc(0,0,1,0,0,0);
    chk("R3 pulse", irq_o, 1);
    chk("R10 count kept", pend_count_o, 3);
    cyc(0,0,0,0,0,0);
    chk("R3 one cycle", irq_o, 0);
    cyc(0,0,1,0,0,0);
    chk("R3 blocked until ack", irq_o, 0);
  endtask

  task automatic t_ack();
    cyc(0,1,0,0,0,0);
    chk("R4 decrement", pend_count_o, 2);
    cyc(0,0,1,0,0,0);
    chk("R4 rearmed", irq_o, 1);
    cyc(0,1,0,0,0,0);
    cyc(0,1,0,0,0,0);
    chk("R4 to zero", pend_count_o, 0);
    cyc(0,1,0,0,0,0);
    chk("R4 floor", pend_count_o, 0);
    chk("R4 pending clear", pending_o, 0);
    cyc(0,0,1,0,0,0);
    chk("R3 no pulse when empty", irq_o, 0);
  endtask

  task automatic t_net();
    cyc(1,0,0,0,0,0);
    cyc(1,0,0,0,0,0);
    cyc(0,0,1,0,0,0);
    chk("R8 setup pulse", irq_o, 1);
    cyc(1,1,0,0,0,0);
    chk("R8 net zero", pend_count_o, 2);
    cyc(0,0,1,0,0,0);
    chk("R8 flag set", irq_o, 1);
  endtask

  task automatic t_unmask();
    cyc(1,1,1,1,0,0);
    chk("R5 clear wins", pend_count_o, 0);
    chk("R5 no pulse on clear", irq_o, 0);
    cyc(1,0,0,0,0,0);
    cyc(0,0,1,0,0,0);
    chk("R5 rearmed", irq_o, 1);
  endtask

  task automatic t_reload();
    cyc(1,0,0,0,0,0);
    chk("R6 setup", pend_count_o, 2);
    cyc(1,0,0,0,1,3'd2);
    chk("R6 clear", pend_count_o, 0);
    chk("R9 periodic", run_periodic_o, 1);
    cyc(1,0,0,0,0,3'd0);
    cyc(0,0,1,0,0,0);
    chk("R6 rearmed", irq_o, 1);
    chk("R9 held", run_periodic_o, 1);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 8; m++) begin
      cyc(0,0,0,0,1,3'(m));
      chk($sformatf("R9 periodic m%0d", m), run_periodic_o, (m == 2 || m == 3) ? 1 : 0);
      chk($sformatf("R9 oneshot m%0d", m), run_oneshot_o, (m == 1 || m == 4) ? 1 : 0);
    end
  endtask

  task automatic t_sat();
    cyc(0,0,0,1,0,0);
    for (int k = 0; k < CMAX + 5; k++) cyc(1,0,0,0,0,0);
    chk("R7 saturate", pend_count_o, CMAX);
    cyc(0,1,0,0,0,0);
    chk("R7 one below max", pend_count_o, CMAX - 1);
  endtask

  initial begin
    rst_n = 0;
    expire_i = 0; ack_i = 0; inject_req_i = 0; unmask_i = 0; reload_i = 0; mode_i = 0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", irq_o, 0);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_issue();
    t_ack();
    t_net();
    t_unmask();
    t_reload();
    t_modes();
    t_sat();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule